// File: doc/BRIEF.md
# Pointer-Addressed SMBus Register Target

This block is a two-wire serial bus target that lets a host reach a small register file through an internal pointer. It runs entirely on the system clock. The clock and data lines are passed through a short synchroniser, and the block watches the result for clock edges and for start and stop conditions. It answers one fixed 7-bit bus address and leaves the bus alone for every other address.

Three transaction shapes are served. A write-direction address followed by one byte is a pointer set: that byte loads the pointer and nothing else changes. A write-direction address followed by two bytes is a register write: the first byte loads the pointer and the second is written to the register the pointer now selects. A read-direction address returns the register the pointer selects, with no pointer byte needed first. A repeated start may join a pointer set to the read that follows it.

The controller is one state machine with the states ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_CMD, ST_CMD_ACK, ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RDATA_ACK, ST_RD_MORE and ST_IGNORE. A stop moves any state to ST_IDLE and a start moves any state to ST_ADDR. ST_ADDR goes to ST_ADDR_ACK on an address match and to ST_IGNORE otherwise. ST_ADDR_ACK goes to ST_CMD for a write or to ST_RDATA for a read. ST_CMD goes to ST_CMD_ACK and then to ST_WDATA, which goes to ST_WDATA_ACK and then to ST_IGNORE. ST_RDATA goes to ST_RDATA_ACK. That state goes to ST_RD_MORE on a host acknowledge, which returns to ST_RDATA, or to ST_IGNORE on a host no-acknowledge.

Top module: `smb_ptr_target`

## Requirements
- R1: After reset the block drives no pull-down on the data line, issues no register write, and the pointer holds 0.
- R2: When the 7 address bits after a start equal the configured address, the block pulls the data line low for the whole ninth clock. The direction bit that follows the address uses 0 for write and 1 for read.
- R3: When the address does not match, the block acknowledges neither the address nor any later byte, and it writes no register until the next start or stop.
- R4: The first byte after a matching write address loads the pointer and is acknowledged. A stop after it changes no register.
- R5: A second byte after the pointer byte is acknowledged and produces exactly one single-cycle write strobe carrying the pointer and that byte.
- R6: After a matching read address, the block shifts out the selected register most significant bit first, with no pointer write needed beforehand.
- R7: After the host answers a read byte with a no-acknowledge, the data line is released. A stop always leaves the data line released.
- R8: A repeated start in place of a stop is decoded as a fresh address phase.
- R9: A pointer value at or above the number of implemented registers still acknowledges a write byte but issues no write strobe. A read at such a pointer returns 0x00.
- R10: The pointer keeps its value across transactions until the next pointer byte.
- R11: Bytes sent after the data byte of a register write are not acknowledged and are not written.
- R12: The block changes its data-line pull-down only while the synchronised clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line, as seen at the pad |
| sda_in | input | 1 | Bus data line, as seen at the pad |
| sda_pull | output | 1 | 1 pulls the open-drain data line low |
| reg_addr | output | 8 | Current pointer, used as register-file address |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_data | output | 8 | Data for the register write |
| reg_rd_data | input | 8 | Register-file read data at reg_addr |

## Verification
The hardest case to reach is the repeated start that follows a pointer byte. The block has just released the line after its acknowledge and sits in ST_WDATA waiting for data. The host then raises the clock with data high and drops data while the clock is still high, so a partial bit is counted before the start must clear it. The bench host model builds this exact edge order, then reads at once and expects the register the new pointer selects. Two cases with no visible activity are handled at the pins: an out-of-range write, and the bytes after a wrong address. For each one the bench checks the acknowledge bits, an empty write queue, and a later read-back through the bus.

// File: rtl/smb_pkg.sv
package smb_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK,
        ST_RD_MORE,
        ST_IGNORE
    } smb_state_e;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;

    // Idle bus is high, so every stage resets high.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    // Data edges only count as conditions while the clock stays high.
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/smb_bit_shifter.sv
module smb_bit_shifter #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            shift_in,
    input  logic            shift_out,
    input  logic            load,
    input  logic [BITS-1:0] load_val,
    input  logic            sda_s,
    output logic [BITS-1:0] rx_next,
    output logic            last_bit,
    output logic            tx_next
);

    localparam int CNT_W = $clog2(BITS);

    logic [BITS-2:0]  rx_sr;
    logic [BITS-2:0]  tx_sr;
    logic [CNT_W-1:0] cnt;

    assign rx_next  = {rx_sr, sda_s};
    assign last_bit = (cnt == CNT_W'(BITS - 1));
    assign tx_next  = tx_sr[BITS-2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            rx_sr <= '0;
        end else if (clear) begin
            cnt   <= '0;
        end else if (shift_in) begin
            cnt   <= cnt + CNT_W'(1);
            rx_sr <= rx_next[BITS-2:0];
        end
    end

    // The top bit of a loaded byte goes straight to the pin; only the rest waits here.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr <= '0;
        end else if (load) begin
            tx_sr <= load_val[BITS-2:0];
        end else if (shift_out) begin
            tx_sr <= {tx_sr[BITS-3:0], 1'b0};
        end
    end

endmodule

// File: rtl/smb_ptr_port.sv
module smb_ptr_port #(
    parameter int PTR_W    = 8,
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_load,
    input  logic [PTR_W-1:0]  ptr_val,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wr_val,
    input  logic [DATA_W-1:0] reg_rd_data,
    output logic [PTR_W-1:0]  reg_addr,
    output logic              reg_wr_en,
    output logic [DATA_W-1:0] reg_wr_data,
    output logic [DATA_W-1:0] rd_byte
);

    logic [PTR_W-1:0] ptr_q;
    logic             in_range;

    assign in_range = ({1'b0, ptr_q} < (PTR_W+1)'(NUM_REGS));
    assign reg_addr = ptr_q;
    assign rd_byte  = in_range ? reg_rd_data : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q       <= '0;
            reg_wr_en   <= 1'b0;
            reg_wr_data <= '0;
        end else begin
            if (ptr_load) begin
                ptr_q <= ptr_val;
            end
            reg_wr_en <= wr_req & in_range;
            if (wr_req) begin
                reg_wr_data <= wr_val;
            end
        end
    end

endmodule

// File: rtl/smb_ptr_target.sv
module smb_ptr_target #(
    parameter logic [6:0] TGT_ADDR    = 7'h2E,
    parameter int         NUM_REGS    = 16,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_pull,
    output logic [7:0] reg_addr,
    output logic       reg_wr_en,
    output logic [7:0] reg_wr_data,
    input  logic [7:0] reg_rd_data
);

    import smb_pkg::*;

    localparam int PTR_W = BYTE_W;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic sh_clear, sh_in, sh_out, sh_load;
    logic [BYTE_W-1:0] rx_next;
    logic [BYTE_W-1:0] rd_byte;
    logic last_bit, tx_next;
    logic ptr_load, wr_req;

    smb_state_e state_q, state_d;
    logic       phase_q, phase_d;   // ack slot: 0 = waiting to drive, 1 = driving
    logic       rw_q, rw_d;
    logic       pull_q, pull_d;

    smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    smb_bit_shifter #(.BITS(BYTE_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (sh_clear),
        .shift_in  (sh_in),
        .shift_out (sh_out),
        .load      (sh_load),
        .load_val  (rd_byte),
        .sda_s     (sda_s),
        .rx_next   (rx_next),
        .last_bit  (last_bit),
        .tx_next   (tx_next)
    );

    smb_ptr_port #(.PTR_W(PTR_W), .DATA_W(BYTE_W), .NUM_REGS(NUM_REGS)) u_ptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .ptr_load    (ptr_load),
        .ptr_val     (rx_next),
        .wr_req      (wr_req),
        .wr_val      (rx_next),
        .reg_rd_data (reg_rd_data),
        .reg_addr    (reg_addr),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_data (reg_wr_data),
        .rd_byte     (rd_byte)
    );

    // State register process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            phase_q <= 1'b0;
            rw_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            phase_q <= phase_d;
            rw_q    <= rw_d;
        end
    end

    // Output register process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pull_q <= 1'b0;
        end else begin
            pull_q <= pull_d;
        end
    end

    assign sda_pull = pull_q;

    // Next state and per-cycle control.
    always_comb begin
        state_d  = state_q;
        phase_d  = phase_q;
        rw_d     = rw_q;
        pull_d   = pull_q;
        sh_clear = 1'b0;
        sh_in    = 1'b0;
        sh_out   = 1'b0;
        sh_load  = 1'b0;
        ptr_load = 1'b0;
        wr_req   = 1'b0;

        if (stop_det) begin
            state_d = ST_IDLE;
            phase_d = 1'b0;
            pull_d  = 1'b0;
        end else if (start_det) begin
            state_d  = ST_ADDR;
            phase_d  = 1'b0;
            pull_d   = 1'b0;
            sh_clear = 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_IGNORE: begin
                    pull_d = 1'b0;
                end
                ST_ADDR: begin
                    if (scl_rise) begin
                        sh_in = 1'b1;
                        if (last_bit) begin
                            if (rx_next[BYTE_W-1:1] == TGT_ADDR) begin
                                state_d = ST_ADDR_ACK;
                                rw_d    = rx_next[0];
                            end else begin
                                state_d = ST_IGNORE;
                            end
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        if (!phase_q) begin
                            pull_d  = 1'b1;
                            phase_d = 1'b1;
                        end else begin
                            phase_d  = 1'b0;
                            sh_clear = 1'b1;
                            if (rw_q) begin
                                state_d = ST_RDATA;
                                sh_load = 1'b1;
                                pull_d  = ~rd_byte[BYTE_W-1];
                            end else begin
                                state_d = ST_CMD;
                                pull_d  = 1'b0;
                            end
                        end
                    end
                end
                ST_CMD: begin
                    if (scl_rise) begin
                        sh_in = 1'b1;
                        if (last_bit) begin
                            ptr_load = 1'b1;
                            state_d  = ST_CMD_ACK;
                        end
                    end
                end
                ST_CMD_ACK: begin
                    if (scl_fall) begin
                        if (!phase_q) begin
                            pull_d  = 1'b1;
                            phase_d = 1'b1;
                        end else begin
                            phase_d  = 1'b0;
                            pull_d   = 1'b0;
                            sh_clear = 1'b1;
                            state_d  = ST_WDATA;
                        end
                    end
                end
                ST_WDATA: begin
                    if (scl_rise) begin
                        sh_in = 1'b1;
                        if (last_bit) begin
                            wr_req  = 1'b1;
                            state_d = ST_WDATA_ACK;
                        end
                    end
                end
                ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        if (!phase_q) begin
                            pull_d  = 1'b1;
                            phase_d = 1'b1;
                        end else begin
                            phase_d = 1'b0;
                            pull_d  = 1'b0;
                            state_d = ST_IGNORE;
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) begin
                        sh_in = 1'b1;
                        if (last_bit) begin
                            state_d = ST_RDATA_ACK;
                        end
                    end else if (scl_fall) begin
                        sh_out = 1'b1;
                        pull_d = ~tx_next;
                    end
                end
                ST_RDATA_ACK: begin
                    if (scl_fall && !phase_q) begin
                        pull_d  = 1'b0;
                        phase_d = 1'b1;
                    end else if (scl_rise && phase_q) begin
                        phase_d = 1'b0;
                        state_d = sda_s ? ST_IGNORE : ST_RD_MORE;
                    end
                end
                ST_RD_MORE: begin
                    if (scl_fall) begin
                        sh_clear = 1'b1;
                        sh_load  = 1'b1;
                        pull_d   = ~rd_byte[BYTE_W-1];
                        state_d  = ST_RDATA;
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    pull_d  = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/smb_ptr_chk.sv
module smb_ptr_chk #(
    parameter int NUM_REGS = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       sda_pull,
    input logic       scl_s,
    input logic       stop_det,
    input logic       reg_wr_en,
    input logic [7:0] reg_addr
);

    AST_PULL_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> !scl_s) else $error("pull changed with clock high"); // R12

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_pull) else $error("line held after stop"); // R7

    AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> ({1'b0, reg_addr} < 9'(NUM_REGS))) else $error("write outside range"); // R9

    AST_WRITE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en) else $error("write strobe longer than one cycle"); // R5

endmodule

bind smb_ptr_target smb_ptr_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_pull  (sda_pull),
    .scl_s     (scl_s),
    .stop_det  (stop_det),
    .reg_wr_en (reg_wr_en),
    .reg_addr  (reg_addr)
);

// File: tb/test_smb_ptr_target.sv
`timescale 1ns/1ps
module test_smb_ptr_target;

    localparam logic [6:0] MY_ADDR    = 7'h2E;
    localparam logic [6:0] OTHER_ADDR = 7'h2C;
    localparam int         T          = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       host_low = 1'b0;
    logic       sda_pull;
    logic [7:0] reg_addr;
    logic       reg_wr_en;
    logic [7:0] reg_wr_data;
    logic [7:0] reg_rd_data;
    logic       sda_line;
    logic [7:0] regs [16];

    int n_chk  = 0;
    int n_fail = 0;
    logic [15:0] exp_q [$];

    always #2.5 clk = ~clk;

    assign sda_line    = ~(host_low | sda_pull);
    assign reg_rd_data = (reg_addr < 8'd16) ? regs[reg_addr[3:0]] : 8'hEE;

    smb_ptr_target #(.TGT_ADDR(MY_ADDR), .NUM_REGS(16), .SYNC_STAGES(2)) i_smb_ptr_target (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_in      (scl),
        .sda_in      (sda_line),
        .sda_pull    (sda_pull),
        .reg_addr    (reg_addr),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_data (reg_wr_data),
        .reg_rd_data (reg_rd_data)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Register-file model and scoreboard monitor.
    always @(negedge clk) begin
        if (rst_n && reg_wr_en) begin
            regs[reg_addr[3:0]] <= reg_wr_data;
            if (exp_q.size() == 0) begin
                check("R3/R4/R9/R11 unexpected write", {reg_addr, reg_wr_data}, 16'hxxxx);
            end else begin
                check("R5 write strobe", {reg_addr, reg_wr_data}, exp_q.pop_front());
            end
        end
    end

    task automatic wait_t(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        host_low = 1'b0; wait_t(T);
        scl = 1'b1;      wait_t(T);
        host_low = 1'b1; wait_t(T);
        scl = 1'b0;      wait_t(T);
    endtask

    task automatic bus_stop();
        host_low = 1'b1; wait_t(T);
        scl = 1'b1;      wait_t(T);
        host_low = 1'b0; wait_t(T);
    endtask

    task automatic put_bit(input logic b);
        host_low = ~b; wait_t(T);
        scl = 1'b1;    wait_t(T);
        scl = 1'b0;    wait_t(T);
    endtask

    task automatic get_bit(output logic b);
        host_low = 1'b0; wait_t(T);
        scl = 1'b1;      wait_t(T/2);
        b = sda_line;    wait_t(T - T/2);
        scl = 1'b0;      wait_t(T);
    endtask

    task automatic put_byte(input logic [7:0] d, output logic nack);
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(nack);
    endtask

    task automatic get_byte(output logic [7:0] d, input logic nack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        put_bit(nack);
    endtask

    task automatic set_ptr(input logic [7:0] p);
        logic nk;
        bus_start();
        put_byte({MY_ADDR, 1'b0}, nk); check("R2 address ack", 16'(nk), 16'h0);
        put_byte(p, nk);               check("R4 pointer byte ack", 16'(nk), 16'h0);
        bus_stop();
    endtask

    task automatic write_reg(input logic [7:0] p, input logic [7:0] d);
        logic nk;
        if (p < 8'd16) exp_q.push_back({p, d});
        bus_start();
        put_byte({MY_ADDR, 1'b0}, nk); check("R2 address ack", 16'(nk), 16'h0);
        put_byte(p, nk);               check("R4 pointer byte ack", 16'(nk), 16'h0);
        put_byte(d, nk);               check("R5/R9 data byte ack", 16'(nk), 16'h0);
        bus_stop();
    endtask

    task automatic read_reg(input logic [7:0] exp, input string req, input logic with_start);
        logic nk;
        logic [7:0] d;
        if (with_start) bus_start();
        put_byte({MY_ADDR, 1'b1}, nk); check("R2 read address ack", 16'(nk), 16'h0);
        get_byte(d, 1'b1);
        check(req, 16'(d), 16'(exp));
        check("R7 released after no-ack", 16'(sda_pull), 16'h0);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic nk;
        for (int i = 0; i < 16; i++) regs[i] = 8'h30 + 8'(i);
        wait_t(5);
        check("R1 no pull in reset", 16'(sda_pull), 16'h0);
        rst_n = 1'b1;
        wait_t(5);
        check("R1 no write after reset", 16'(reg_wr_en), 16'h0);
        check("R1 pointer zero", 16'(reg_addr), 16'h0);

        // R6: read with no pointer write returns register 0.
        read_reg(8'h30, "R6 read without pointer write", 1'b1);

        // R5: write byte, then read back through a pointer set.
        write_reg(8'h05, 8'hA5);
        set_ptr(8'h05);
        check("R4 pointer after send byte", 16'(reg_addr), 16'h0005);
        read_reg(8'hA5, "R6/R10 read back after write", 1'b1);

        // R8: pointer byte joined to the read by a repeated start.
        bus_start();
        put_byte({MY_ADDR, 1'b0}, nk); check("R2 address ack", 16'(nk), 16'h0);
        put_byte(8'h03, nk);           check("R4 pointer byte ack", 16'(nk), 16'h0);
        bus_start();
        read_reg(8'h33, "R8 read after repeated start", 1'b0);

        // R3: foreign address is never acknowledged and changes nothing.
        bus_start();
        put_byte({OTHER_ADDR, 1'b0}, nk); check("R3 no address ack", 16'(nk), 16'h1);
        put_byte(8'h07, nk);              check("R3 no pointer ack", 16'(nk), 16'h1);
        put_byte(8'h99, nk);              check("R3 no data ack", 16'(nk), 16'h1);
        bus_stop();
        read_reg(8'h33, "R3/R10 pointer unchanged by foreign address", 1'b1);

        // R9: out-of-range pointer.
        write_reg(8'h40, 8'h77);
        read_reg(8'h00, "R9 out-of-range read is zero", 1'b1);

        // R11: extra byte after a register write.
        exp_q.push_back({8'h02, 8'h5A});
        bus_start();
        put_byte({MY_ADDR, 1'b0}, nk); check("R2 address ack", 16'(nk), 16'h0);
        put_byte(8'h02, nk);           check("R4 pointer byte ack", 16'(nk), 16'h0);
        put_byte(8'h5A, nk);           check("R5 data byte ack", 16'(nk), 16'h0);
        put_byte(8'h11, nk);           check("R11 extra byte not acked", 16'(nk), 16'h1);
        bus_stop();
        read_reg(8'h5A, "R11 extra byte not written", 1'b1);

        wait_t(20);
        check("R5 all expected writes seen", 16'(exp_q.size()), 16'h0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule